// File: doc/BRIEF.md
# Programmable Frame Slot Locator

The locator keeps track of where the current bit slot sits inside a frame on a double-data-rate serial bus. Each frame is a grid of rows by columns, and frames follow one another with no gap. The block steps one slot per slot clock edge. It walks the columns of a row first and then moves on to the next row. It reports the current row and column, a start-of-frame flag and an end-of-row flag. Downstream multiplexing logic uses these outputs to place data from several sources into fixed, periodic positions in the bit stream.

The row count (48 to 256) and the column count (2 to 16) are programmable. A setting outside its legal range is clamped to the nearest limit. The block samples the settings during the first slot of each frame and holds them for the rest of that frame, so a change made mid-frame takes effect only when the next frame begins. A synchronous restart input puts the position back to the first slot so that the count can be realigned once frame sync is found.

The block's clock is the bit-slot clock. Each of its rising edges stands for one half cycle of the bus clock, so it runs at twice the bus clock rate and is produced upstream from both edges of the bus clock.

Top module: `frame_slot_locator`

## Requirements
- R1: While reset is asserted and in the first slot after reset, row_o and col_o are 0, sof_o is 1 and eor_o is 0.
- R2: Each rising edge of clk_i advances the position by exactly one slot. Within a row, col_o increments by one and row_o holds.
- R3: After the last column (col_o = columns-1), col_o returns to 0 and row_o increments by one.
- R4: After the last slot of the last row, the position returns to row 0, column 0. Frames repeat back to back: there are exactly rows*columns slots from one sof_o slot to the next, with sof_o high only in slot (0,0).
- R5: A row setting below 48 acts as 48, and a setting above 256 acts as 256.
- R6: A column setting below 2 acts as 2, and a setting above 16 acts as 16.
- R7: The dimensions are sampled from rows_i and cols_i during the sof_o slot. Changes applied later in a frame do not alter that frame's length and take effect from the next frame.
- R8: When restart_i is high at a clock edge, the next slot is row 0, column 0 with sof_o high. Counting then resumes from there.
- R9: eor_o is high exactly in slots where col_o = columns-1, once per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-slot clock, one rising edge per slot |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Synchronous realign to slot (0,0) |
| rows_i | input | 9 | Requested row count, clamped to 48..256 |
| cols_i | input | 5 | Requested column count, clamped to 2..16 |
| row_o | output | 8 | Current row index |
| col_o | output | 4 | Current column index |
| sof_o | output | 1 | High in the first slot of a frame |
| eor_o | output | 1 | High in the last column of each row |

## Verification
The stepping assertions assume that restart_i is a plain synchronous control. They also assume that the dimension inputs are free to change in any slot, because the design itself holds them except at slot (0,0). The stimulus changes every input on the falling clock edge, so each input is stable around the rising edge. It moves the dimensions mid-frame, at the frame start and to out-of-range values on purpose. The bound and clamp properties therefore cover unclamped input values as well as latched ones.

// File: rtl/frame_pkg.sv
package frame_pkg;
  parameter int ROW_MIN = 48;
  parameter int ROW_MAX = 256;
  parameter int COL_MIN = 2;
  parameter int COL_MAX = 16;
  localparam int ROW_W  = $clog2(ROW_MAX);
  localparam int COL_W  = $clog2(COL_MAX);
  localparam int RCFG_W = $clog2(ROW_MAX + 1);
  localparam int CCFG_W = $clog2(COL_MAX + 1);
endpackage

// File: rtl/dim_clamp.sv
module dim_clamp #(
  parameter int W   = 9,
  parameter int MIN = 48,
  parameter int MAX = 256
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  generate
    if (MIN == 0) begin : g_top_only
      always_comb val_o = (val_i > MAX_V) ? MAX_V : val_i;
    end else begin : g_both
      always_comb begin
        if (val_i < MIN_V)      val_o = MIN_V;
        else if (val_i > MAX_V) val_o = MAX_V;
        else                    val_o = val_i;
      end
    end
  endgenerate
endmodule

// File: rtl/dim_shadow.sv
module dim_shadow #(
  parameter int W       = 9,
  parameter int RST_VAL = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= W'(RST_VAL);
    else if (load_i) act_q <= live_i;
  end

  // first slot of a frame follows the live setting; rest of frame holds it
  assign eff_o = load_i ? live_i : act_q;

  AST_DIMS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q)) else $error("dims changed mid-frame"); // R7
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 4,
  parameter int RCFG_W = 9,
  parameter int CCFG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [RCFG_W-1:0] rows_i,
  input  logic [CCFG_W-1:0] cols_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              sof_o,
  output logic              eor_o
);
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [RCFG_W-1:0] last_row;
  logic [CCFG_W-1:0] last_col;
  logic              at_last_row;

  assign last_row    = rows_i - 1'b1;
  assign last_col    = cols_i - 1'b1;
  assign at_last_row = (RCFG_W'(row_q) == last_row);
  assign eor_o       = (CCFG_W'(col_q) == last_col);
  assign sof_o       = (row_q == '0) && (col_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (restart_i) begin
      row_q <= '0;
      col_q <= '0;
    end else if (eor_o) begin
      col_q <= '0;
      row_q <= at_last_row ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  AST_COL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CCFG_W'(col_q) < cols_i) else $error("column past end"); // R3
  AST_ROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    RCFG_W'(row_q) < rows_i) else $error("row past end"); // R4
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !eor_o) |=> (col_o == $past(col_o) + 1'b1) && $stable(row_o))
    else $error("bad column step"); // R2
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && eor_o && !at_last_row) |=> (col_o == '0) && (row_o == $past(row_o) + 1'b1))
    else $error("bad row step"); // R3
  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && eor_o && at_last_row) |=> sof_o) else $error("no wrap"); // R4
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> sof_o) else $error("restart ignored"); // R8
endmodule

// File: rtl/frame_slot_locator.sv
module frame_slot_locator
  import frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [RCFG_W-1:0] rows_i,
  input  logic [CCFG_W-1:0] cols_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              sof_o,
  output logic              eor_o
);
  logic [RCFG_W-1:0] rows_cl, rows_eff;
  logic [CCFG_W-1:0] cols_cl, cols_eff;
  logic              sof;

  dim_clamp #(.W(RCFG_W), .MIN(ROW_MIN), .MAX(ROW_MAX)) u_row_clamp (
    .val_i(rows_i), .val_o(rows_cl));
  dim_clamp #(.W(CCFG_W), .MIN(COL_MIN), .MAX(COL_MAX)) u_col_clamp (
    .val_i(cols_i), .val_o(cols_cl));

  dim_shadow #(.W(RCFG_W), .RST_VAL(ROW_MIN)) u_row_shadow (
    .clk_i, .rst_ni, .load_i(sof), .live_i(rows_cl), .eff_o(rows_eff));
  dim_shadow #(.W(CCFG_W), .RST_VAL(COL_MIN)) u_col_shadow (
    .clk_i, .rst_ni, .load_i(sof), .live_i(cols_cl), .eff_o(cols_eff));

  slot_counter #(.ROW_W(ROW_W), .COL_W(COL_W), .RCFG_W(RCFG_W), .CCFG_W(CCFG_W)) u_cnt (
    .clk_i, .rst_ni, .restart_i,
    .rows_i(rows_eff), .cols_i(cols_eff),
    .row_o, .col_o, .sof_o(sof), .eor_o);

  assign sof_o = sof;

  AST_ROWS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rows_eff >= RCFG_W'(ROW_MIN)) && (rows_eff <= RCFG_W'(ROW_MAX)))
    else $error("row count out of range"); // R5
  AST_COLS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cols_eff >= CCFG_W'(COL_MIN)) && (cols_eff <= CCFG_W'(COL_MAX)))
    else $error("column count out of range"); // R6
endmodule

// File: tb/tb_frame_slot_locator.sv
module tb_frame_slot_locator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic [8:0] rows = 9'd48;
  logic [4:0] cols = 5'd4;
  logic [7:0] row;
  logic [3:0] col;
  logic       sof, eor;
  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  frame_slot_locator dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart),
    .rows_i(rows), .cols_i(cols),
    .row_o(row), .col_o(col), .sof_o(sof), .eor_o(eor));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sync_sof();
    while (!sof) @(negedge clk);
  endtask

  // from a sof slot, walk to the next sof slot
  task automatic run_frame(output int len, output int eors, output int mc, output int mr);
    len = 0; eors = 0; mc = 0; mr = 0;
    do begin
      if (eor) eors++;
      if (int'(col) > mc) mc = int'(col);
      if (int'(row) > mr) mr = int'(row);
      len++;
      @(negedge clk);
    end while (!sof);
  endtask

  task automatic t_reset();
    #2ns;
    chk("R1", "row in reset", int'(row), 0);
    chk("R1", "col in reset", int'(col), 0);
    chk("R1", "sof in reset", int'(sof), 1);
    chk("R1", "eor in reset", int'(eor), 0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1", "sof first slot", int'(sof), 1);
  endtask

  task automatic t_step();
    rows = 9'd48; cols = 5'd4;
    sync_sof();
    for (int i = 0; i < 9; i++) begin
      chk("R2", "col step", int'(col), i % 4);
      chk("R3", "row step", int'(row), i / 4);
      chk("R9", "eor flag", int'(eor), (i % 4 == 3) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_frame(input int r_set, input int c_set, input int r_exp, input int c_exp,
                         input string req);
    int len, eors, mc, mr;
    rows = 9'(r_set); cols = 5'(c_set);
    sync_sof();
    run_frame(len, eors, mc, mr);
    chk(req, "frame length", len, r_exp * c_exp);
    chk("R9", "eor count", eors, r_exp);
    chk(req, "max col", mc, c_exp - 1);
    chk(req, "max row", mr, r_exp - 1);
    chk("R4", "wrap row", int'(row), 0);
    chk("R4", "wrap col", int'(col), 0);
  endtask

  task automatic t_midframe();
    int len, eors, mc, mr;
    rows = 9'd48; cols = 5'd4;
    sync_sof();
    len = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); len++; end
    rows = 9'd50; cols = 5'd6;
    while (!sof) begin @(negedge clk); len++; end
    chk("R7", "frame kept old dims", len, 192);
    run_frame(len, eors, mc, mr);
    chk("R7", "next frame new dims", len, 300);
    chk("R7", "next frame cols", mc, 5);
  endtask

  task automatic t_restart();
    int len, eors, mc, mr;
    rows = 9'd48; cols = 5'd3;
    sync_sof();
    for (int i = 0; i < 37; i++) @(negedge clk);
    chk("R8", "not at sof before restart", int'(sof), 0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R8", "row after restart", int'(row), 0);
    chk("R8", "col after restart", int'(col), 0);
    chk("R8", "sof after restart", int'(sof), 1);
    run_frame(len, eors, mc, mr);
    chk("R8", "frame after restart", len, 144);
  endtask

  initial begin
    t_reset();
    t_step();
    t_frame(48, 2, 48, 2, "R4");
    t_frame(64, 16, 64, 16, "R4");
    t_frame(256, 3, 256, 3, "R4");
    t_frame(10, 0, 48, 2, "R5");
    t_frame(300, 31, 256, 16, "R6");
    t_frame(0, 17, 48, 16, "R6");
    t_frame(511, 1, 256, 2, "R5");
    t_midframe();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500us;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule